// File: doc/BRIEF.md
# Interrupt Event and Graceful-Stop Controller

This block holds the interrupt event register of an Ethernet DMA engine and drives its three interrupt lines: transmit, receive and error. Datapath logic reports events as one-cycle set pulses. Software clears events by writing ones. The block raises a line when an unmasked event of that line's group is set. It lowers the line only when a clear leaves the whole group empty.

It also acts on writes to the DMA control word. A graceful stop request, for transmit or for receive, completes at once when that direction is idle. When a frame is in flight, completion waits for the frame's end-of-frame pulse. A write with the wait-on-poll bit clear starts a periodic transmit poll. Each poll tick kicks transmit ring 0, unless a graceful transmit stop is set. If wait-on-poll has been set again by the time of a tick, polling stops. The poll period is a clock-cycle divider, `POLL_DIV`. Its default gives 100 ticks per second at 100 MHz.

Top module: `ievc_top`

## Requirements
- R1: After reset the event register reads zero, all three interrupt lines are low, `tx_kick` is low and no polling runs.
- R2: A clear write removes every event bit written as one, in the cycle after the write. If a set pulse and a clear of the same bit arrive in the same cycle, the bit stays set.
- R3: A set pulse on `ev_set[b]` makes `ev_q[b]` one in the next cycle. Bit 0 is transmit-frame, bit 1 is receive-frame, bit 2 is transmit-stop-complete, bit 3 is receive-stop-complete, and every other bit is in the error group. Bits 2 and 3 are also in the error group. If `ev_mask[b]` is one, the line of the bit's group rises in the next cycle. A masked-off set records the bit and leaves the line unchanged.
- R4: A clear write lowers `irq_tx` only if bit 0 is zero after the clear, and lowers `irq_rx` only if bit 1 is zero after the clear. It lowers `irq_err` only if no error-group bit is still set.
- R5: The control word has wait-on-poll at bit 0, graceful transmit stop at bit 1 and graceful receive stop at bit 2. A control write with bit 2 set while `rx_busy` is low sets event bit 3 in the next cycle. That raises `irq_err` if `ev_mask[3]` is one.
- R6: A receive stop requested while `rx_busy` is high does not set bit 3 until an `rx_eof` pulse arrives. Bit 3 is then set in the cycle after that pulse. A later control write with bit 2 clear withdraws the pending request.
- R7: Graceful transmit stop follows R5 and R6, using control bit 1, `tx_busy`, `tx_eof` and event bit 2.
- R8: A control write with bit 0 clear restarts the poll timer. `tx_kick` then pulses for one cycle every `POLL_DIV` cycles, with the first pulse `POLL_DIV` cycles after the write.
- R9: A poll tick while the stored control word has bit 1 set gives no kick, and polling continues. A tick while the stored bit 0 is set gives no kick and stops polling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_clr_we | input | 1 | Write-one-to-clear strobe for the event register |
| ev_clr_data | input | EVW | Bits to clear |
| ev_set | input | EVW | One-cycle event set pulses from the datapath |
| ev_mask | input | EVW | Interrupt mask, one enables the event |
| ctl_wr | input | 1 | DMA control word write strobe |
| ctl_data | input | 3 | Control word {rx stop, tx stop, wait-on-poll} |
| tx_busy | input | 1 | A transmit frame is in progress |
| rx_busy | input | 1 | A receive frame is in progress |
| tx_eof | input | 1 | End-of-frame pulse, transmit |
| rx_eof | input | 1 | End-of-frame pulse, receive |
| ev_q | output | EVW | Event register contents |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rx | output | 1 | Receive interrupt line |
| irq_err | output | 1 | Error interrupt line |
| tx_kick | output | 1 | One-cycle request to scan transmit ring 0 |

## Verification
The bench clears one of two set error events and checks that the error line stays high. A design that lowered the line on any clear would drop it too early. It also sets and clears the same bit in one cycle, where a design that let the clear win would lose the event. It asks for graceful stops while a frame is in progress, with and without a withdrawal before the end-of-frame pulse. A design that did not defer would report the stop early, and one that ignored the withdrawal would report a stop nobody still wants. It measures the poll interval exactly, then sets the stop and wait-on-poll bits. A timer that was off by one cycle, or that kept kicking after either bit was set, would fail these checks.

// File: rtl/ievc_pkg.sv
package ievc_pkg;
   // Control word layout; the bench and the writer both decode it
   typedef struct packed {
      logic rx_stop;   // bit 2
      logic tx_stop;   // bit 1
      logic wait_poll; // bit 0
   } ievc_ctl_t;

   localparam int unsigned CTL_W = $bits(ievc_ctl_t);
   localparam int unsigned N_DIR = 2; // 0: transmit, 1: receive
endpackage

// File: rtl/ievc_stop_track.sv
module ievc_stop_track (
   input  logic clk,
   input  logic rst_n,
   input  logic req_wr,
   input  logic req_bit,
   input  logic busy,
   input  logic eof,
   output logic done
);
   logic pend_q;

   always_comb begin
      done = (req_wr & req_bit & (~busy | eof)) |
             (~req_wr & pend_q & eof);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (req_wr) begin
         pend_q <= req_bit & busy & ~eof;
      end else if (eof) begin
         pend_q <= 1'b0;
      end
   end
endmodule

// File: rtl/ievc_poll_timer.sv
module ievc_poll_timer #(
   parameter int unsigned POLL_DIV = 1000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic wop_q,
   input  logic gts_q,
   output logic kick
);
   localparam int unsigned CW = (POLL_DIV > 2) ? $clog2(POLL_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(POLL_DIV - 1);

   logic          run_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         kick  <= 1'b0;
      end else if (restart) begin
         run_q <= 1'b1;
         cnt_q <= '0;
         kick  <= 1'b0;
      end else if (run_q && cnt_q == LAST) begin
         cnt_q <= '0;
         if (wop_q) begin
            run_q <= 1'b0;
            kick  <= 1'b0;
         end else begin
            kick  <= ~gts_q;
         end
      end else begin
         if (run_q) cnt_q <= cnt_q + 1'b1;
         kick <= 1'b0;
      end
   end
endmodule

// File: rtl/ievc_event_regs.sv
module ievc_event_regs #(
   parameter int unsigned EVW     = 16,
   parameter int unsigned TXF_BIT = 0,
   parameter int unsigned RXF_BIT = 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr_we,
   input  logic [EVW-1:0] clr_data,
   input  logic [EVW-1:0] set_vec,
   input  logic [EVW-1:0] mask,
   output logic [EVW-1:0] ev_q,
   output logic           irq_tx,
   output logic           irq_rx,
   output logic           irq_err
);
   localparam logic [EVW-1:0] TXM  = EVW'(1) << TXF_BIT;
   localparam logic [EVW-1:0] RXM  = EVW'(1) << RXF_BIT;
   localparam logic [EVW-1:0] ERRM = ~(TXM | RXM);

   logic [EVW-1:0] ev_d;
   logic [EVW-1:0] hit;

   always_comb begin
      ev_d = (ev_q & ~(clr_we ? clr_data : '0)) | set_vec;
      hit  = set_vec & mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ev_q    <= '0;
         irq_tx  <= 1'b0;
         irq_rx  <= 1'b0;
         irq_err <= 1'b0;
      end else begin
         ev_q <= ev_d;
         if (|(hit & TXM))                        irq_tx <= 1'b1;
         else if (clr_we && (ev_d & TXM) == '0)   irq_tx <= 1'b0;
         if (|(hit & RXM))                        irq_rx <= 1'b1;
         else if (clr_we && (ev_d & RXM) == '0)   irq_rx <= 1'b0;
         if (|(hit & ERRM))                       irq_err <= 1'b1;
         else if (clr_we && (ev_d & ERRM) == '0)  irq_err <= 1'b0;
      end
   end
endmodule

// File: rtl/ievc_top.sv
module ievc_top
   import ievc_pkg::*;
#(
   parameter int unsigned EVW      = 16,
   parameter int unsigned TXF_BIT  = 0,
   parameter int unsigned RXF_BIT  = 1,
   parameter int unsigned GTSC_BIT = 2,
   parameter int unsigned GRSC_BIT = 3,
   parameter int unsigned POLL_DIV = 1000000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_clr_we,
   input  logic [EVW-1:0]   ev_clr_data,
   input  logic [EVW-1:0]   ev_set,
   input  logic [EVW-1:0]   ev_mask,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_data,
   input  logic             tx_busy,
   input  logic             rx_busy,
   input  logic             tx_eof,
   input  logic             rx_eof,
   output logic [EVW-1:0]   ev_q,
   output logic             irq_tx,
   output logic             irq_rx,
   output logic             irq_err,
   output logic             tx_kick
);
   initial begin
      assert (POLL_DIV >= 2) else $error("POLL_DIV must be at least 2");
      assert (TXF_BIT < EVW && RXF_BIT < EVW && GTSC_BIT < EVW && GRSC_BIT < EVW)
         else $error("event bit outside register");
      assert (TXF_BIT != RXF_BIT && GTSC_BIT != GRSC_BIT &&
              GTSC_BIT != TXF_BIT && GTSC_BIT != RXF_BIT &&
              GRSC_BIT != TXF_BIT && GRSC_BIT != RXF_BIT)
         else $error("event bits must be distinct");
   end

   ievc_ctl_t      ctl_q;
   ievc_ctl_t      ctl_in;
   logic [N_DIR-1:0] dir_req, dir_busy, dir_eof, dir_done;
   logic [EVW-1:0] set_vec;

   always_comb begin
      ctl_in   = ievc_ctl_t'(ctl_data);
      dir_req  = {ctl_in.rx_stop, ctl_in.tx_stop};
      dir_busy = {rx_busy, tx_busy};
      dir_eof  = {rx_eof, tx_eof};
      set_vec  = ev_set;
      if (dir_done[0]) set_vec[GTSC_BIT] = 1'b1;
      if (dir_done[1]) set_vec[GRSC_BIT] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_wr) ctl_q <= ctl_in;
   end

   for (genvar d = 0; d < N_DIR; d++) begin : g_dir
      ievc_stop_track u_stop (
         .clk    (clk),
         .rst_n  (rst_n),
         .req_wr (ctl_wr),
         .req_bit(dir_req[d]),
         .busy   (dir_busy[d]),
         .eof    (dir_eof[d]),
         .done   (dir_done[d])
      );
   end

   ievc_event_regs #(
      .EVW(EVW), .TXF_BIT(TXF_BIT), .RXF_BIT(RXF_BIT)
   ) u_ev (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_we  (ev_clr_we),
      .clr_data(ev_clr_data),
      .set_vec (set_vec),
      .mask    (ev_mask),
      .ev_q    (ev_q),
      .irq_tx  (irq_tx),
      .irq_rx  (irq_rx),
      .irq_err (irq_err)
   );

   ievc_poll_timer #(.POLL_DIV(POLL_DIV)) u_poll (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(ctl_wr & ~ctl_in.wait_poll),
      .wop_q  (ctl_q.wait_poll),
      .gts_q  (ctl_q.tx_stop),
      .kick   (tx_kick)
   );
endmodule

// File: rtl/ievc_chk.sv
module ievc_chk #(
   parameter int unsigned EVW      = 16,
   parameter int unsigned TXF_BIT  = 0,
   parameter int unsigned RXF_BIT  = 1,
   parameter int unsigned GTSC_BIT = 2,
   parameter int unsigned GRSC_BIT = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           ev_clr_we,
   input logic [EVW-1:0] ev_clr_data,
   input logic [EVW-1:0] ev_set,
   input logic [EVW-1:0] ev_mask,
   input logic           ctl_wr,
   input logic [2:0]     ctl_data,
   input logic           rx_busy,
   input logic [EVW-1:0] ev_q,
   input logic           irq_tx,
   input logic           irq_err,
   input logic           tx_kick
);
   localparam logic [EVW-1:0] STOPM = (EVW'(1) << GTSC_BIT) | (EVW'(1) << GRSC_BIT);
   localparam logic [EVW-1:0] ERRM  = ~((EVW'(1) << TXF_BIT) | (EVW'(1) << RXF_BIT));

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev_set) |=> ((ev_q & $past(ev_set)) == $past(ev_set))); // R2
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      ev_clr_we |=> ((ev_q & $past(ev_clr_data & ~ev_set & ~STOPM)) == '0)); // R2
   AST_TX_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_set[TXF_BIT] && ev_mask[TXF_BIT]) |=> irq_tx); // R3
   AST_TX_FALL_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_tx) |-> ($past(ev_clr_we) && !ev_q[TXF_BIT])); // R4
   AST_ERR_FALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_err) |-> ((ev_q & ERRM) == '0)); // R4
   AST_RX_STOP_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_data[2] && !rx_busy) |=> ev_q[GRSC_BIT]); // R5
   AST_KICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_kick |=> !tx_kick); // R8
endmodule

bind ievc_top ievc_chk #(
   .EVW(EVW), .TXF_BIT(TXF_BIT), .RXF_BIT(RXF_BIT),
   .GTSC_BIT(GTSC_BIT), .GRSC_BIT(GRSC_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ev_clr_we(ev_clr_we), .ev_clr_data(ev_clr_data),
   .ev_set(ev_set), .ev_mask(ev_mask), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
   .rx_busy(rx_busy), .ev_q(ev_q), .irq_tx(irq_tx), .irq_err(irq_err),
   .tx_kick(tx_kick)
);

// File: tb/tb_ievc_top.sv
module tb_ievc_top;
   localparam int unsigned EVW = 16;
   localparam int unsigned DIV = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ev_clr_we = 1'b0;
   logic [EVW-1:0] ev_clr_data = '0;
   logic [EVW-1:0] ev_set = '0;
   logic [EVW-1:0] ev_mask = '1;
   logic           ctl_wr = 1'b0;
   logic [2:0]     ctl_data = '0;
   logic           tx_busy = 1'b0, rx_busy = 1'b0, tx_eof = 1'b0, rx_eof = 1'b0;
   logic [EVW-1:0] ev_q;
   logic           irq_tx, irq_rx, irq_err, tx_kick;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   ievc_top #(.EVW(EVW), .POLL_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .ev_clr_we(ev_clr_we), .ev_clr_data(ev_clr_data),
      .ev_set(ev_set), .ev_mask(ev_mask), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
      .tx_busy(tx_busy), .rx_busy(rx_busy), .tx_eof(tx_eof), .rx_eof(rx_eof),
      .ev_q(ev_q), .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err),
      .tx_kick(tx_kick)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic set_pulse(input logic [EVW-1:0] v);
      @(negedge clk) ev_set = v;
      @(negedge clk) ev_set = '0;
   endtask

   task automatic clear(input logic [EVW-1:0] v);
      @(negedge clk) begin ev_clr_we = 1'b1; ev_clr_data = v; end
      @(negedge clk) begin ev_clr_we = 1'b0; ev_clr_data = '0; end
   endtask

   task automatic ctl(input logic [2:0] v);
      @(negedge clk) begin ctl_wr = 1'b1; ctl_data = v; end
      @(negedge clk) ctl_wr = 1'b0;
   endtask

   task automatic eof(input bit tx, input bit rx);
      @(negedge clk) begin tx_eof = tx; rx_eof = rx; end
      @(negedge clk) begin tx_eof = 1'b0; rx_eof = 1'b0; end
   endtask

   task automatic t_reset;
      chk(ev_q == '0, "R1 event reg", ev_q, 0);
      chk({irq_tx, irq_rx, irq_err, tx_kick} == 4'b0, "R1 lines", {irq_tx, irq_rx, irq_err, tx_kick}, 0);
      repeat (2 * DIV) @(negedge clk);
      chk(tx_kick == 1'b0, "R1 no poll", tx_kick, 0);
   endtask

   task automatic t_set_raise;
      set_pulse(16'h0001);
      chk(ev_q[0] && irq_tx && !irq_rx && !irq_err, "R3 tx set", {irq_tx, irq_rx, irq_err}, 3'b100);
      set_pulse(16'h0002);
      chk(ev_q[1] && irq_rx && !irq_err, "R3 rx set", {irq_tx, irq_rx, irq_err}, 3'b110);
      set_pulse(16'h0060);
      chk(ev_q == 16'h0063 && irq_err, "R3 err set", ev_q, 16'h0063);
   endtask

   task automatic t_clear_groups;
      clear(16'h0020);
      chk(ev_q == 16'h0043 && irq_err, "R4 err partial clear keeps line", {ev_q, irq_err}, {16'h0043, 1'b1});
      chk(irq_tx && irq_rx, "R4 other lines kept", {irq_tx, irq_rx}, 2'b11);
      clear(16'h0040);
      chk(ev_q == 16'h0003 && !irq_err, "R4 err group empty", {ev_q, irq_err}, {16'h0003, 1'b0});
      clear(16'h0001);
      chk(!irq_tx && irq_rx && ev_q == 16'h0002, "R2 tx clear", {irq_tx, irq_rx}, 2'b01);
      clear(16'h0002);
      chk(!irq_rx && ev_q == '0, "R4 rx clear", {ev_q, irq_rx}, 0);
   endtask

   task automatic t_masked;
      ev_mask = 16'hFFBF;
      set_pulse(16'h0040);
      chk(ev_q[6] && !irq_err, "R3 masked set no raise", {ev_q[6], irq_err}, 2'b10);
      ev_mask = '1;
      clear(16'h0040);
      chk(ev_q == '0 && !irq_err, "R2 masked clear", ev_q, 0);
   endtask

   task automatic t_set_wins;
      @(negedge clk) begin ev_set = 16'h0080; ev_clr_we = 1'b1; ev_clr_data = 16'h0080; end
      @(negedge clk) begin ev_set = '0; ev_clr_we = 1'b0; ev_clr_data = '0; end
      chk(ev_q[7] && irq_err, "R2 set beats clear", {ev_q[7], irq_err}, 2'b11);
      clear(16'h0080);
      chk(ev_q == '0 && !irq_err, "R2 cleanup", ev_q, 0);
   endtask

   task automatic t_rx_stop;
      ctl(3'b101);
      chk(ev_q[3] && irq_err, "R5 rx stop now", {ev_q[3], irq_err}, 2'b11);
      clear(16'h0008);
      ev_mask = 16'hFFF7;
      ctl(3'b101);
      chk(ev_q[3] && !irq_err, "R5 rx stop masked", {ev_q[3], irq_err}, 2'b10);
      ev_mask = '1;
      clear(16'h0008);
      rx_busy = 1'b1;
      ctl(3'b101);
      chk(!ev_q[3], "R6 deferred while busy", ev_q[3], 0);
      repeat (3) @(negedge clk);
      chk(!ev_q[3], "R6 still deferred", ev_q[3], 0);
      eof(1'b0, 1'b1);
      chk(ev_q[3] && irq_err, "R6 completes at eof", {ev_q[3], irq_err}, 2'b11);
      clear(16'h0008);
      ctl(3'b101);
      ctl(3'b001);
      eof(1'b0, 1'b1);
      chk(!ev_q[3], "R6 withdrawn request", ev_q[3], 0);
      rx_busy = 1'b0;
   endtask

   task automatic t_tx_stop;
      tx_busy = 1'b1;
      ctl(3'b011);
      chk(!ev_q[2], "R7 tx deferred", ev_q[2], 0);
      eof(1'b0, 1'b1);
      chk(!ev_q[2], "R7 rx eof ignored", ev_q[2], 0);
      eof(1'b1, 1'b0);
      chk(ev_q[2] && irq_err, "R7 tx completes at eof", {ev_q[2], irq_err}, 2'b11);
      tx_busy = 1'b0;
      clear(16'h0004);
      ctl(3'b011);
      chk(ev_q[2] && !ev_q[3], "R7 tx stop now", ev_q, 16'h0004);
      clear(16'h0004);
   endtask

   task automatic wait_kick(output int n);
      n = 0;
      while (n < 4 * DIV) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (tx_kick) break;
      end
   endtask

   task automatic kicks_in(input int cycles, output int k);
      k = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (tx_kick) k++;
      end
   endtask

   task automatic t_poll;
      int n;
      int k;
      ctl(3'b000);
      wait_kick(n);
      chk(n == DIV, "R8 first kick interval", n, DIV);
      wait_kick(n);
      chk(n == DIV, "R8 periodic interval", n, DIV);
      ctl(3'b010);
      kicks_in(3 * DIV, k);
      chk(k == 0, "R9 stop bit suppresses kick", k, 0);
      ctl(3'b000);
      wait_kick(n);
      chk(n == DIV, "R9 polling kept running", n, DIV);
      ctl(3'b001);
      kicks_in(3 * DIV, k);
      chk(k == 0, "R9 wait-on-poll stops polling", k, 0);
      clear('1);
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set_raise();
      t_clear_groups();
      t_masked();
      t_set_wins();
      t_rx_stop();
      t_tx_stop();
      t_poll();
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
   end
endmodule